// File: doc/BRIEF.md
# Internal Register Window Decoder

This block sits between a CPU's physical address bus and a bank of on-chip control registers. It recognises accesses that fall inside a 64 KB register window and reports a hit together with the 16-bit register offset. The window answers at two aliased bases. One is a fixed default base at physical address 0xF_FF1F_0000. The other is a programmable base held in a remap register inside this block. An access through either base reaches the same register.

The decoder also steers data lanes. Registers come in two widths, and the register file reports the width of the addressed register on `tgt_is64`. A 64-bit register can be accessed in one 64-bit transfer or as two 32-bit halves. The half that a 32-bit access selects depends on address bit 2 and on the endian mode. Illegal accesses raise an error flag: a 64-bit access to a 32-bit-only register, or a 64-bit access with address bit 2 set. An erroring access never writes and reads back zero. The hit flag, the offset, the lane controls and the write strobe are combinational. Read data is registered and appears one clock after the request.

Top module: `regwin_decoder`

## Requirements
- R1: With `req_valid` high, `hit` is 1 exactly when `req_addr[35:16]` equals the default base bits 0xFFF1F or the remap register. In that case `offset` equals `req_addr[15:0]`. With no hit, `wr_en` is 0 and no read data is returned (`rd_valid` is 0 in the next cycle).
- R2: After reset the remap register holds 0xFFF1F. A write through `remap_we`/`remap_wdata` moves the second base to `remap_wdata` as address bits [35:16]. Afterwards an access through that base hits with the same offset, and the default base still hits.
- R3: When `remap_we` is high in the same cycle as an access, the access is decoded against the old remap value. The new value takes effect from the next cycle.
- R4: In big-endian mode (`big_endian`=1), a 32-bit access to a 64-bit register selects bits [63:32] when `req_addr[2]`=0 (`half_hi`=1, `wr_be`=2'b10). It selects bits [31:0] when `req_addr[2]`=1 (`half_hi`=0, `wr_be`=2'b01).
- R5: In little-endian mode (`big_endian`=0), the selection of R4 is reversed: `req_addr[2]`=0 selects bits [31:0] and `req_addr[2]`=1 selects bits [63:32].
- R6: A 64-bit access (`req_is64`=1) to a 64-bit register with `req_addr[2]`=0 gives `half_hi`=0, `wr_be`=2'b11, `wr_data`=`req_wdata`, and a read returns all 64 bits of `reg_rdata`.
- R7: A 64-bit access to a 32-bit register (`tgt_is64`=0) sets `err`, forces `wr_en` to 0, and a read from it returns `rd_data`=0.
- R8: A 64-bit access with `req_addr[2]`=1 sets `err`, forces `wr_en` to 0, and a read from it returns zero.
- R9: A read hit sets `rd_valid` on the following clock. A 32-bit read returns the selected half in `rd_data[31:0]` with bits [63:32] zero. For a 32-bit register, that half is always bits [31:0] (`half_hi`=0, `wr_be`=2'b01).
- R10: For a 32-bit write, `wr_data` carries `req_wdata[31:0]` in both halves, and `wr_be` marks the half to be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 36 | Physical address |
| req_is64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data from the bus |
| big_endian | input | 1 | Endian mode, 1 = big-endian |
| tgt_is64 | input | 1 | Addressed register is 64 bits wide |
| reg_rdata | input | 64 | Raw contents of the addressed register |
| remap_we | input | 1 | Remap register write enable |
| remap_wdata | input | 20 | New remap base, address bits [35:16] |
| hit | output | 1 | Access falls in the register window |
| offset | output | 16 | Register offset inside the window |
| half_hi | output | 1 | 32-bit access targets bits [63:32] |
| err | output | 1 | Illegal access size or alignment |
| wr_en | output | 1 | Write strobe to the register file |
| wr_be | output | 2 | Half enables, bit 1 = [63:32], bit 0 = [31:0] |
| wr_data | output | 64 | Lane-steered write data |
| rd_valid | output | 1 | Registered read data valid |
| rd_data | output | 64 | Registered, bus-aligned read data |

## Verification
The remap update and the address match can fall in the same cycle. This happens when software moves the second base while an access is already under way. The bench provokes it by raising `remap_we` with a new base while it presents an address that only the new base would hit. It checks that `hit` stays low in that cycle. It then checks that the same address hits on the next cycle once the write has landed. The endian half selection and the error check also meet on one access: a misaligned 64-bit access in either endian mode must report an error and never a half.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned PA_W    = 36;
  localparam int unsigned WIN_W   = 16;
  localparam int unsigned BASE_W  = PA_W - WIN_W;
  localparam int unsigned BUS_W   = 64;
  localparam int unsigned HALF_W  = BUS_W / 2;
  localparam logic [PA_W-1:0] DEF_BASE_PA = 36'hF_FF1F_0000;
  localparam logic [BASE_W-1:0] DEF_BASE  = DEF_BASE_PA[PA_W-1:WIN_W];

  typedef struct packed {
    logic       half_hi;
    logic [1:0] be;
    logic       err;
  } lane_ctl_t;
endpackage

// File: rtl/regwin_remap.sv
module regwin_remap #(
  parameter int unsigned BASE_W = 20,
  parameter logic [BASE_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst) base_q <= RST_VAL;
    else if (we) base_q <= wdata;
  end

  // R3: a write lands on the following edge, not before
  a_r3_remap_update: assert property (@(posedge clk) disable iff (rst)
    we |=> (base_q == $past(wdata)));
  a_r2_remap_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(base_q));
endmodule

// File: rtl/regwin_match.sv
module regwin_match #(
  parameter int unsigned BASE_W = 20,
  parameter int unsigned NBASE  = 2
) (
  input  logic                         valid,
  input  logic [BASE_W-1:0]            addr_hi,
  input  logic [NBASE-1:0][BASE_W-1:0] bases,
  output logic                         hit
);
  logic [NBASE-1:0] eq;

  for (genvar i = 0; i < NBASE; i++) begin : g_cmp
    assign eq[i] = (addr_hi == bases[i]);
  end

  assign hit = valid & (|eq);
endmodule

// File: rtl/regwin_lane.sv
module regwin_lane
  import regwin_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          hit,
  input  logic          is64,
  input  logic          tgt_is64,
  input  logic          addr2,
  input  logic          big_endian,
  input  logic [DW-1:0] wdata_in,
  output lane_ctl_t     ctl,
  output logic [DW-1:0] wdata_out
);
  localparam int unsigned HW = DW / 2;

  logic misalign;
  logic size_bad;
  logic pick_hi;

  always_comb begin
    misalign = is64 & addr2;
    size_bad = is64 & ~tgt_is64;
    // big-endian: bit2 clear -> upper; little-endian: bit2 clear -> lower
    pick_hi  = ~is64 & tgt_is64 & (big_endian ^ addr2);
    ctl.err     = hit & (misalign | size_bad);
    ctl.half_hi = pick_hi;
    if (is64)         ctl.be = 2'b11;
    else if (pick_hi) ctl.be = 2'b10;
    else              ctl.be = 2'b01;
    if (is64) wdata_out = wdata_in;
    else      wdata_out = {wdata_in[HW-1:0], wdata_in[HW-1:0]};
  end
endmodule

// File: rtl/regwin_rdpipe.sv
module regwin_rdpipe #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          kill,
  input  logic          full,
  input  logic          half_hi,
  input  logic [DW-1:0] raw,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] aligned;

  always_comb begin
    if (kill)         aligned = '0;
    else if (full)    aligned = raw;
    else if (half_hi) aligned = {{HW{1'b0}}, raw[DW-1:HW]};
    else              aligned = {{HW{1'b0}}, raw[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= aligned;
    end
  end

  // R9: read answers arrive one clock after the request
  a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  // R7/R8: an erroring read returns zero
  a_r7_err_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && kill) |=> (rd_data == '0));
  // R9: a 32-bit read leaves the upper lanes clear
  a_r9_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !full) |=> (rd_data[DW-1:HW] == '0));
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [PA_W-1:0]   req_addr,
  input  logic              req_is64,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              big_endian,
  input  logic              tgt_is64,
  input  logic [BUS_W-1:0]  reg_rdata,
  input  logic              remap_we,
  input  logic [BASE_W-1:0] remap_wdata,
  output logic              hit,
  output logic [WIN_W-1:0]  offset,
  output logic              half_hi,
  output logic              err,
  output logic              wr_en,
  output logic [1:0]        wr_be,
  output logic [BUS_W-1:0]  wr_data,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int unsigned NBASE = 2;

  logic [BASE_W-1:0]            remap_q;
  logic [NBASE-1:0][BASE_W-1:0] base_set;
  lane_ctl_t                    ctl;

  regwin_remap #(.BASE_W(BASE_W), .RST_VAL(DEF_BASE)) u_remap (
    .clk(clk), .rst(rst), .we(remap_we), .wdata(remap_wdata), .base_q(remap_q)
  );

  assign base_set[0] = DEF_BASE;
  assign base_set[1] = remap_q;

  regwin_match #(.BASE_W(BASE_W), .NBASE(NBASE)) u_match (
    .valid(req_valid), .addr_hi(req_addr[PA_W-1:WIN_W]),
    .bases(base_set), .hit(hit)
  );

  regwin_lane #(.DW(BUS_W)) u_lane (
    .hit(hit), .is64(req_is64), .tgt_is64(tgt_is64), .addr2(req_addr[2]),
    .big_endian(big_endian), .wdata_in(req_wdata),
    .ctl(ctl), .wdata_out(wr_data)
  );

  assign offset  = req_addr[WIN_W-1:0];
  assign half_hi = ctl.half_hi;
  assign err     = ctl.err;
  assign wr_be   = ctl.be;
  assign wr_en   = hit & req_write & ~ctl.err;

  regwin_rdpipe #(.DW(BUS_W)) u_rd (
    .clk(clk), .rst(rst), .rd_req(hit & ~req_write), .kill(ctl.err),
    .full(req_is64), .half_hi(ctl.half_hi), .raw(reg_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R7/R8: an illegal access never reaches the register file
  a_r7_err_blocks_write: assert property (@(posedge clk) disable iff (rst)
    err |-> !wr_en);
  // R1: nothing is written outside the window
  a_r1_miss_no_write: assert property (@(posedge clk) disable iff (rst)
    !hit |-> !wr_en);
  a_r1_miss_no_read: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !rd_valid);
  // R4/R5: a 32-bit write enables exactly one half
  a_r4_one_half: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !req_is64) |-> $onehot0(wr_be) && (wr_be != 2'b00));
endmodule

// File: tb/regwin_decoder_bench.sv
module regwin_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_is64, req_write, big_endian, tgt_is64, remap_we;
  logic [35:0] req_addr;
  logic [63:0] req_wdata, reg_rdata;
  logic [19:0] remap_wdata;
  logic        hit, half_hi, err, wr_en, rd_valid;
  logic [15:0] offset;
  logic [1:0]  wr_be;
  logic [63:0] wr_data, rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [35:0] DEF = 36'hF_FF1F_0000;
  localparam logic [63:0] PAT = 64'h1111_2222_3333_4444;

  always #10 clk = ~clk;

  regwin_decoder u_regwin_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_is64(req_is64), .req_write(req_write), .req_wdata(req_wdata),
    .big_endian(big_endian), .tgt_is64(tgt_is64), .reg_rdata(reg_rdata),
    .remap_we(remap_we), .remap_wdata(remap_wdata), .hit(hit),
    .offset(offset), .half_hi(half_hi), .err(err), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; req_is64 = 0; remap_we = 0;
  endtask

  // present an access at the negedge, let comb outputs settle
  task automatic drive(input logic [35:0] a, input logic w, input logic is64,
                       input logic be_mode, input logic t64);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_is64 = is64;
    big_endian = be_mode; tgt_is64 = t64;
    #1;
  endtask

  // finish the cycle and look at registered read data
  task automatic close_read(input string tag, input logic [63:0] exp);
    @(posedge clk);
    @(negedge clk);
    idle();
    chk({tag, " rd_valid"}, {63'b0, rd_valid}, 64'd1);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 reset rd_valid", {63'b0, rd_valid}, 64'd0);
    chk("R9 reset rd_data", rd_data, 64'd0);
    drive(DEF | 36'h0040, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 reset remap aliases default hit", {63'b0, hit}, 64'd1);
    close_read("R2 reset", {32'b0, PAT[31:0]});
  endtask

  task automatic t_window();
    drive(DEF | 36'hABC8, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R1 hit", {63'b0, hit}, 64'd1);
    chk("R1 offset", {48'b0, offset}, 64'hABC8);
    chk("R1 wr_en", {63'b0, wr_en}, 64'd1);
    drive(36'hF_FF20_0008, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R1 miss hit", {63'b0, hit}, 64'd0);
    chk("R1 miss wr_en", {63'b0, wr_en}, 64'd0);
    req_write = 0; #1;
    @(posedge clk); @(negedge clk);
    chk("R1 miss rd_valid", {63'b0, rd_valid}, 64'd0);
    idle();
  endtask

  task automatic t_remap();
    logic [35:0] nb;
    nb = 36'h1_2345_0000;
    drive(nb | 36'h0010, 1'b0, 1'b0, 1'b1, 1'b0);
    remap_we = 1; remap_wdata = 20'h12345; #1;
    chk("R3 same-cycle old base", {63'b0, hit}, 64'd0);
    @(negedge clk);
    remap_we = 0; #1;
    chk("R3 new base next cycle", {63'b0, hit}, 64'd1);
    chk("R2 remap offset", {48'b0, offset}, 64'h0010);
    drive(DEF | 36'h0010, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 default still hits", {63'b0, hit}, 64'd1);
    idle();
  endtask

  task automatic t_endian();
    reg_rdata = PAT;
    drive(DEF | 36'h0100, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 BE bit2=0 half_hi", {63'b0, half_hi}, 64'd1);
    chk("R4 BE bit2=0 be", {62'b0, wr_be}, 64'd2);
    drive(DEF | 36'h0104, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 BE bit2=1 half_hi", {63'b0, half_hi}, 64'd0);
    close_read("R4 BE low", {32'b0, PAT[31:0]});
    drive(DEF | 36'h0108, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 LE bit2=0 be", {62'b0, wr_be}, 64'd1);
    close_read("R5 LE low", {32'b0, PAT[31:0]});
    drive(DEF | 36'h010C, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 LE bit2=1 half_hi", {63'b0, half_hi}, 64'd1);
    close_read("R5 LE high", {32'b0, PAT[63:32]});
  endtask

  task automatic t_full();
    req_wdata = 64'hDEAD_BEEF_0123_4567;
    drive(DEF | 36'h0200, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R6 be", {62'b0, wr_be}, 64'd3);
    chk("R6 wr_data", wr_data, 64'hDEAD_BEEF_0123_4567);
    chk("R6 err", {63'b0, err}, 64'd0);
    drive(DEF | 36'h0200, 1'b0, 1'b1, 1'b0, 1'b1);
    close_read("R6 full read", PAT);
    drive(DEF | 36'h0300, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 32b reg half_hi", {63'b0, half_hi}, 64'd0);
    chk("R9 32b reg be", {62'b0, wr_be}, 64'd1);
    chk("R10 replicated wr_data", wr_data, 64'h0123_4567_0123_4567);
  endtask

  task automatic t_errors();
    drive(DEF | 36'h0400, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R7 size err", {63'b0, err}, 64'd1);
    chk("R7 wr_en blocked", {63'b0, wr_en}, 64'd0);
    drive(DEF | 36'h0400, 1'b0, 1'b1, 1'b1, 1'b0);
    close_read("R7 read zero", 64'd0);
    drive(DEF | 36'h0504, 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R8 misalign err", {63'b0, err}, 64'd1);
    chk("R8 wr_en blocked", {63'b0, wr_en}, 64'd0);
    drive(DEF | 36'h0504, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 misalign err BE", {63'b0, err}, 64'd1);
    close_read("R8 read zero", 64'd0);
  endtask

  initial begin
    rst = 1; idle();
    req_addr = '0; req_wdata = 64'h0; big_endian = 0; tgt_is64 = 0;
    reg_rdata = PAT; remap_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_window();
    t_remap();
    t_endian();
    t_full();
    t_errors();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule